// File: doc/BRIEF.md
# UART Register Front-End with Watermark Interrupt

This block is the software-facing side of a simple serial port. A 32-bit, word-only bus port reaches a small set of registers. Those registers cover outgoing data, incoming data, interrupt enables, pending flags, two control words and a baud divisor. The incoming side is a byte stream with a valid/ready handshake. It feeds a receive FIFO, and software drains that FIFO by reading the receive-data register. The outgoing side has no queue. Every accepted write to the transmit-data register produces a one-cycle byte strobe on the outgoing byte stream.

The block reports two watermark conditions as pending flags and also drives them on pins. It has one level-sensitive interrupt line. The interrupt line does not follow the pending flags. It is raised when the transmit enable bit is set, or when the receive enable bit is set and the FIFO holds any byte. Read data is combinational in the cycle of the access. The FIFO pop caused by that read takes effect at the clock edge that ends the access. The bit-level serial shifter and the baud timing sit outside this block.

Top module: `uart_regfront`

## Requirements
- R1: A full-word read of the receive-data register (offset 0x04) while the FIFO holds data returns the oldest byte in bits [7:0], with the upper bits zero, and removes that byte at the end of the access.
- R2: A full-word read of offset 0x04 while the FIFO is empty returns 0x80000000 and leaves the FIFO unchanged.
- R3: Pending bit 1 (receive watermark, offset 0x14, also pin `wm_rx`) is high exactly when the FIFO occupancy is strictly greater than bits [18:16] of the receive control register (offset 0x0C).
- R4: Pending bit 0 (transmit watermark, also pin `wm_tx`) is high exactly when bits [18:16] of the transmit control register (offset 0x08) are nonzero.
- R5: `irq` is high exactly when enable bit 0 (offset 0x10) is set, or when enable bit 1 is set and the FIFO is not empty.
- R6: The FIFO holds 8 bytes. `rx_ready` is low exactly when it is full. A byte offered while it is full is discarded and leaves the contents unchanged.
- R7: A full-word write to offset 0x00 drives `tx_valid` high for the single following cycle, with `tx_data` equal to bits [7:0] of the written word.
- R8: The enable (0x10), transmit control (0x08), receive control (0x0C) and divisor (0x18) registers read back the whole 32-bit word last written. All four are zero after reset.
- R9: A read of offset 0x00 returns zero. Writes to offset 0x14 are ignored. Any other offset reads as zero and ignores writes. `bus_rdata` is zero in any cycle with no valid read.
- R10: An access whose byte strobes are not all ones has no effect. Such a read returns zero and pops nothing, and such a write changes no register and sends no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_strb | input | 4 | Byte strobes; only 4'b1111 is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| wm_tx | output | 1 | Transmit watermark flag |
| wm_rx | output | 1 | Receive watermark flag |
| irq | output | 1 | Level interrupt |

## Verification
The stimulus starts with directed runs. One run fills the FIFO past capacity while the receive threshold sits mid-range. This separates the strict greater-than comparison from greater-or-equal, and shows whether overflow bytes are dropped or overwrite older ones. Reads from an empty FIFO and reads issued in the same cycle as a push tell the empty marker apart from a stale head byte, and show whether pop and push interact correctly. Partial-strobe accesses, unmapped and misaligned offsets, and writes to the pending register are each followed by readback, to show that nothing changed. The directed runs are followed by a long random mix of accesses and incoming bytes. In that mix, the interrupt line is checked against its own condition and not against the pending flags.

// File: rtl/urf_pkg.sv
package urf_pkg;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned BYTE_W = 8;

   localparam logic [7:0] OFF_TXDATA = 8'h00;
   localparam logic [7:0] OFF_RXDATA = 8'h04;
   localparam logic [7:0] OFF_TXCTRL = 8'h08;
   localparam logic [7:0] OFF_RXCTRL = 8'h0C;
   localparam logic [7:0] OFF_IEN    = 8'h10;
   localparam logic [7:0] OFF_PEND   = 8'h14;
   localparam logic [7:0] OFF_DIVISOR = 8'h18;

   localparam logic [BUS_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

   typedef struct packed {
      logic rx;
      logic tx;
   } wm_t;

endpackage

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned W = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     in_data,
   output logic             in_ready,
   input  logic             out_pop,
   output logic [W-1:0]     out_data,
   output logic [OCC_W-1:0] occ
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("urf_rx_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             full, empty, do_push, do_pop;

   assign full     = (occ == OCC_W'(DEPTH));
   assign empty    = (occ == '0);
   assign in_ready = !full;
   assign do_push  = in_valid && !full;
   assign do_pop   = out_pop && !empty;
   assign out_data = mem[rd_ptr];

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

endmodule

// File: rtl/urf_watermark.sv
module urf_watermark #(
   parameter int unsigned CNT_W = 3,
   parameter int unsigned OCC_W = 4
) (
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic [CNT_W-1:0] rx_cnt,
   input  logic [1:0]       ien,
   input  logic [OCC_W-1:0] occ,
   output urf_pkg::wm_t     pend,
   output logic             irq
);

   localparam int unsigned CMP_W = (CNT_W > OCC_W) ? CNT_W : OCC_W;

   logic [CMP_W-1:0] occ_w, thr_w;

   assign occ_w = CMP_W'(occ);
   assign thr_w = CMP_W'(rx_cnt);

   always_comb begin
      pend.tx = (tx_cnt != '0);
      pend.rx = (occ_w > thr_w);
      irq     = ien[0] || (ien[1] && (occ != '0));
   end

endmodule

// File: rtl/urf_regbank.sv
module urf_regbank
   import urf_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned OCC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_strb,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [OCC_W-1:0]  occ,
   input  logic [BYTE_W-1:0] head,
   input  wm_t               pend,
   output logic              pop,
   output logic [BUS_W-1:0]  ien_q,
   output logic [BUS_W-1:0]  txctrl_q,
   output logic [BUS_W-1:0]  rxctrl_q,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data
);

   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("urf_regbank: ADDR_W must be in 5..8");
   end

   logic [BUS_W-1:0] div_q;
   logic acc_ok, rd_ok, wr_ok;
   logic hit_tx, hit_rx, hit_txc, hit_rxc, hit_ien, hit_pend, hit_div;

   assign acc_ok   = bus_sel && (bus_strb == 4'hF);
   assign rd_ok    = acc_ok && !bus_wr;
   assign wr_ok    = acc_ok && bus_wr;

   assign hit_tx   = (bus_addr == ADDR_W'(OFF_TXDATA));
   assign hit_rx   = (bus_addr == ADDR_W'(OFF_RXDATA));
   assign hit_txc  = (bus_addr == ADDR_W'(OFF_TXCTRL));
   assign hit_rxc  = (bus_addr == ADDR_W'(OFF_RXCTRL));
   assign hit_ien  = (bus_addr == ADDR_W'(OFF_IEN));
   assign hit_pend = (bus_addr == ADDR_W'(OFF_PEND));
   assign hit_div  = (bus_addr == ADDR_W'(OFF_DIVISOR));

   assign pop = rd_ok && hit_rx && (occ != '0);

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         if (hit_rx) begin
            bus_rdata = (occ != '0) ? BUS_W'(head) : RX_EMPTY_WORD;
         end else if (hit_txc) begin
            bus_rdata = txctrl_q;
         end else if (hit_rxc) begin
            bus_rdata = rxctrl_q;
         end else if (hit_ien) begin
            bus_rdata = ien_q;
         end else if (hit_pend) begin
            bus_rdata = {{(BUS_W-2){1'b0}}, pend};
         end else if (hit_div) begin
            bus_rdata = div_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q    <= '0;
         txctrl_q <= '0;
         rxctrl_q <= '0;
         div_q    <= '0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= wr_ok && hit_tx;
         if (wr_ok && hit_tx)  tx_data  <= bus_wdata[BYTE_W-1:0];
         if (wr_ok && hit_ien) ien_q    <= bus_wdata;
         if (wr_ok && hit_txc) txctrl_q <= bus_wdata;
         if (wr_ok && hit_rxc) rxctrl_q <= bus_wdata;
         if (wr_ok && hit_div) div_q    <= bus_wdata;
      end
   end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import urf_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned RX_DEPTH = 8,
   parameter int unsigned CNT_LSB = 16,
   parameter int unsigned CNT_W = 3,
   localparam int unsigned OCC_W = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_strb,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              wm_tx,
   output logic              wm_rx,
   output logic              irq
);

   if (CNT_LSB + CNT_W > BUS_W) begin : g_bad_field
      $error("uart_regfront: count field exceeds the register width");
   end

   logic [OCC_W-1:0]  occ;
   logic [BYTE_W-1:0] head;
   logic              fifo_pop;
   logic [BUS_W-1:0]  ien_q, txctrl_q, rxctrl_q;
   wm_t               pend;

   urf_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_valid),
      .in_data  (rx_data),
      .in_ready (rx_ready),
      .out_pop  (fifo_pop),
      .out_data (head),
      .occ      (occ)
   );

   urf_regbank #(.ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_strb  (bus_strb),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .occ       (occ),
      .head      (head),
      .pend      (pend),
      .pop       (fifo_pop),
      .ien_q     (ien_q),
      .txctrl_q  (txctrl_q),
      .rxctrl_q  (rxctrl_q),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data)
   );

   urf_watermark #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_wm (
      .tx_cnt (txctrl_q[CNT_LSB +: CNT_W]),
      .rx_cnt (rxctrl_q[CNT_LSB +: CNT_W]),
      .ien    (ien_q[1:0]),
      .occ    (occ),
      .pend   (pend),
      .irq    (irq)
   );

   assign wm_tx = pend.tx;
   assign wm_rx = pend.rx;

endmodule

// File: rtl/urf_checker.sv
module urf_checker
   import urf_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned RX_DEPTH = 8,
   parameter int unsigned CNT_LSB = 16,
   parameter int unsigned CNT_W = 3,
   parameter int unsigned OCC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_strb,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              wm_tx,
   input logic              wm_rx,
   input logic              irq,
   input logic [OCC_W-1:0]  occ,
   input logic [31:0]       ien_q,
   input logic [31:0]       txctrl_q,
   input logic [31:0]       rxctrl_q
);

   logic rd_v, wr_v;
   assign rd_v = bus_sel && !bus_wr && (bus_strb == 4'hF);
   assign wr_v = bus_sel && bus_wr && (bus_strb == 4'hF);

   assert_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_v && bus_addr == ADDR_W'(OFF_RXDATA) && occ != '0 && !rx_valid)
      |=> occ == $past(occ) - 1'b1);

   assert_empty_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_v && bus_addr == ADDR_W'(OFF_RXDATA) && occ == '0) |-> bus_rdata == RX_EMPTY_WORD);

   assert_empty_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_v && bus_addr == ADDR_W'(OFF_RXDATA) && occ == '0 && !rx_valid) |=> occ == '0);

   assert_rx_wm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wm_rx == (32'(occ) > 32'(rxctrl_q[CNT_LSB +: CNT_W])));

   assert_tx_wm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wm_tx == (txctrl_q[CNT_LSB +: CNT_W] != '0));

   assert_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (ien_q[0] || (ien_q[1] && occ != '0)));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(occ) <= RX_DEPTH) && ((32'(occ) == RX_DEPTH) == !rx_ready));

   assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(occ) == RX_DEPTH && !(rd_v && bus_addr == ADDR_W'(OFF_RXDATA)))
      |=> 32'(occ) == RX_DEPTH);

   assert_tx_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_v && bus_addr == ADDR_W'(OFF_TXDATA))
      |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

   assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_v && bus_addr == ADDR_W'(OFF_TXDATA)) |=> !tx_valid);

   assert_ien_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_v && bus_addr == ADDR_W'(OFF_IEN)) |=> ien_q == $past(bus_wdata));

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_v |-> bus_rdata == '0);

   assert_partial_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_strb != 4'hF) |=> ($stable(ien_q) && $stable(txctrl_q) && $stable(rxctrl_q)));

endmodule

bind uart_regfront urf_checker #(
   .ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .wm_tx(wm_tx), .wm_rx(wm_rx),
   .irq(irq), .occ(occ), .ien_q(ien_q), .txctrl_q(txctrl_q), .rxctrl_q(rxctrl_q)
);

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [3:0]  bus_strb = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, wm_tx, wm_rx, irq;
   logic [7:0]  tx_data;

   int total = 0;
   int bad = 0;

   // reference model state
   byte unsigned q[$];
   logic [31:0] m_ien = 0, m_txc = 0, m_rxc = 0, m_div = 0;
   logic        m_txv = 0;
   logic [7:0]  m_txd = 0;

   always #10 clk = ~clk;

   uart_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .wm_tx(wm_tx), .wm_rx(wm_rx), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rdata(output string tag);
      logic [31:0] v;
      v = 0;
      tag = "R9";
      if (bus_sel && !bus_wr) begin
         if (bus_strb != 4'hF) begin
            tag = "R10";
         end else begin
            case (bus_addr)
               5'h04: begin
                  if (q.size() != 0) begin v = {24'h0, q[0]}; tag = "R1"; end
                  else begin v = 32'h8000_0000; tag = "R2"; end
               end
               5'h08: begin v = m_txc; tag = "R8"; end
               5'h0C: begin v = m_rxc; tag = "R8"; end
               5'h10: begin v = m_ien; tag = "R8"; end
               5'h14: begin
                  v = {30'h0, q.size() > int'(m_rxc[18:16]), m_txc[18:16] != 0};
                  tag = "R3";
               end
               5'h18: begin v = m_div; tag = "R8"; end
               default: begin v = 0; tag = "R9"; end
            endcase
         end
      end
      return v;
   endfunction

   task automatic compare_now();
      string t;
      logic [31:0] e;
      e = exp_rdata(t);
      chk(t, bus_rdata, e);
      chk("R7", {31'h0, tx_valid}, {31'h0, m_txv});
      if (m_txv) chk("R7", {24'h0, tx_data}, {24'h0, m_txd});
      chk("R4", {31'h0, wm_tx}, {31'h0, m_txc[18:16] != 0});
      chk("R3", {31'h0, wm_rx}, {31'h0, q.size() > int'(m_rxc[18:16])});
      chk("R5", {31'h0, irq}, {31'h0, m_ien[0] || (m_ien[1] && q.size() != 0)});
      chk("R6", {31'h0, rx_ready}, {31'h0, q.size() < 8});
   endtask

   task automatic model_edge();
      bit full_before;
      bit ok;
      full_before = (q.size() >= 8);
      ok = bus_sel && (bus_strb == 4'hF);
      if (ok && !bus_wr && bus_addr == 5'h04 && q.size() != 0) void'(q.pop_front());
      if (rx_valid && !full_before) q.push_back(rx_data);
      m_txv = ok && bus_wr && bus_addr == 5'h00;
      if (m_txv) m_txd = bus_wdata[7:0];
      if (ok && bus_wr) begin
         case (bus_addr)
            5'h08: m_txc = bus_wdata;
            5'h0C: m_rxc = bus_wdata;
            5'h10: m_ien = bus_wdata;
            5'h18: m_div = bus_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic cyc(input logic sel, input logic wr, input logic [4:0] a, input logic [3:0] s,
                      input logic [31:0] wd, input logic rv, input logic [7:0] rd);
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_strb = s; bus_wdata = wd;
      rx_valid = rv; rx_data = rd;
      #2;
      compare_now();
      @(posedge clk);
      #1;
      model_edge();
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      cyc(1, 1, a, 4'hF, d, 0, 0);
   endtask
   task automatic rd_reg(input logic [4:0] a);
      cyc(1, 0, a, 4'hF, 0, 0, 0);
   endtask
   task automatic push(input logic [7:0] b);
      cyc(0, 0, 0, 0, 0, 1, b);
   endtask
   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state: registers zero (R8), FIFO empty and ready (R6), no strobe (R7)
      idle();
      rd_reg(5'h10); rd_reg(5'h08); rd_reg(5'h0C); rd_reg(5'h18);
      rd_reg(5'h04); // R2 empty
      // R8 readback with full patterns
      wr_reg(5'h18, 32'h1234_ABCD); rd_reg(5'h18);
      wr_reg(5'h08, 32'hFFFF_FFFF); rd_reg(5'h08); rd_reg(5'h14);
      wr_reg(5'h08, 32'h0000_0000); rd_reg(5'h14);
      wr_reg(5'h0C, 32'h0003_0000); rd_reg(5'h0C);
      wr_reg(5'h10, 32'h0000_0002); rd_reg(5'h10);
      // R9: tx read zero, pending write ignored, unmapped and misaligned
      rd_reg(5'h00);
      wr_reg(5'h14, 32'hFFFF_FFFF); rd_reg(5'h14);
      wr_reg(5'h1C, 32'hDEAD_BEEF); rd_reg(5'h1C);
      wr_reg(5'h11, 32'h0000_0001); rd_reg(5'h11); rd_reg(5'h10);
      // R10: partial strobes
      cyc(1, 1, 5'h10, 4'h1, 32'h0000_0001, 0, 0); rd_reg(5'h10);
      cyc(1, 1, 5'h00, 4'h7, 32'h0000_0055, 0, 0); idle();
      // R7: back-to-back transmit writes
      wr_reg(5'h00, 32'hFFFF_FF41); wr_reg(5'h00, 32'h0000_0142); idle(); idle();
      // R6 / R3: fill beyond capacity with threshold 3
      for (int i = 0; i < 10; i++) begin
         push(8'hA0 + 8'(i));
         rd_reg(5'h14);
      end
      cyc(1, 0, 5'h04, 4'h3, 0, 0, 0); // R10: partial read does not pop
      // R1: drain, including a read beyond empty (R2)
      for (int i = 0; i < 9; i++) rd_reg(5'h04);
      // simultaneous push and pop, push while empty read
      cyc(1, 0, 5'h04, 4'hF, 0, 1, 8'h11);
      cyc(1, 0, 5'h04, 4'hF, 0, 1, 8'h22);
      rd_reg(5'h04); rd_reg(5'h04);
      // R5: enable bit 0 alone, then nothing
      wr_reg(5'h10, 32'h1); idle(); wr_reg(5'h10, 32'h0); idle();
      // random mix
      for (int n = 0; n < 4000; n++) begin
         logic [4:0] a;
         logic [3:0] s;
         logic [31:0] d;
         a = 5'(($urandom % 8) * 4);
         if ($urandom % 16 == 0) a = a + 5'(1 + $urandom % 3);
         s = ($urandom % 10 == 0) ? 4'($urandom) : 4'hF;
         d = $urandom;
         if ($urandom % 2 == 0) d[31:19] = 0;
         cyc($urandom % 3 != 0, ($urandom % 3 == 0), a, s, d,
             ($urandom % 2 == 0), 8'($urandom));
      end
      idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule